// File: doc/BRIEF.md
# SD Data Block Engine (1-bit / 4-bit)

This block moves a single data block across the data lines of an SD bus, in either direction. For a write, the host side offers bytes on a valid/ready stream. The engine frames them onto one or four data lanes. Each active lane carries a low start beat, its share of the payload, a 16-bit CRC that is computed only over that lane's bits, and a high end beat. The lanes are then released. The engine next listens on DAT0 alone for the card's reply: a start bit, a three-bit status code, an end-bit slot, and a low busy period. A completion pulse marks the moment the line goes high again.

For a read, the engine is armed. It waits for the start bit on DAT0 and then gathers the incoming beats into bytes, which it presents as single-cycle strobes. It runs a separate CRC over every active lane. When the end beat arrives it reports a single pass/fail flag for the whole block. The block length is a parameter, 512 bytes by default. A mode input, latched at the start of each transfer, selects one lane or four.

Top module: `sd_blk_dat_engine`

## Requirements
- R1: With `wide_i`=0 only DAT0 is driven (`dat_oe_o`=4'b0001 during a block). With `wide_i`=1 all four lanes are driven together (`dat_oe_o`=4'b1111). No other enable pattern ever appears.
- R2: On transmit, every active lane carries a start beat of 0 in the first driven cycle and an end beat of 1 in the last driven cycle.
- R3: Payload bits leave most significant first. In 4-bit mode byte bits [7:4] appear on DAT3..DAT0 in one beat, followed by bits [3:0] on DAT3..DAT0 in the next beat.
- R4: After the payload, each active lane sends 16 CRC beats, most significant bit first. The CRC uses the generator x^16+x^12+x^5+1 and starts from zero, and it covers only the payload bits of that lane.
- R5: A write takes exactly `BLK_BYTES` bytes (default 512), each on a cycle where `tx_ready_o` and `tx_valid_i` are both high. No lane is driven until the first byte has been taken. A block occupies 18 + `BLK_BYTES`·8 beats in 1-bit mode and 18 + `BLK_BYTES`·2 beats in 4-bit mode.
- R6: After `rx_start_i`, the receiver waits for DAT0 low as the start beat. It assembles the payload with the same bit order as R3 and presents each byte in order with a one-cycle `rx_valid_o`.
- R7: `rx_done_o` pulses one cycle after the end beat is sampled. `rx_err_o` is then 1 if the CRC received on any active lane disagrees with the CRC computed on that lane, and 0 otherwise.
- R8: A received end beat of 0 on any active lane also sets `rx_err_o`. Inactive lanes never affect the result.
- R9: After a write, the decoder takes the first low DAT0 sample as the status start bit. It shifts the next three samples, MSB first, into `wr_status_o`. `wr_ok_o` is 1 exactly when the status equals 3'b010.
- R10: After the status end-bit slot, `wr_done_o` pulses in the cycle after the first high sample of DAT0. It never pulses while DAT0 is held low.
- R11: DAT1..DAT3 have no effect on the status or on the busy decoding.
- R12: In reset, `dat_oe_o`, `tx_ready_o`, `rx_valid_o`, `rx_done_o`, `wr_done_o` and `busy_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-rate clock; one beat per cycle |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| wide_i | input | 1 | 1 selects four lanes, 0 selects DAT0 only; latched per transfer |
| tx_start_i | input | 1 | Begins a write block when idle |
| tx_data_i | input | 8 | Payload byte offered by the host |
| tx_valid_i | input | 1 | `tx_data_i` holds a byte |
| tx_ready_o | output | 1 | Engine takes `tx_data_i` this cycle if valid |
| rx_start_i | input | 1 | Arms the receiver when idle |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | One-cycle strobe for `rx_data_o` |
| rx_done_o | output | 1 | One-cycle strobe at the end of a received block |
| rx_err_o | output | 1 | Block result, valid with `rx_done_o` |
| wr_done_o | output | 1 | One-cycle strobe when the card leaves busy |
| wr_status_o | output | 3 | Status code from the card, valid with `wr_done_o` |
| wr_ok_o | output | 1 | Status code means accepted |
| dat_i | input | 4 | Sampled data lanes |
| dat_o | output | 4 | Driven data lanes |
| dat_oe_o | output | 4 | Per-lane output enable |
| busy_o | output | 1 | Any transfer or status phase in progress |

## Verification
The busiest coincidence on the transmit side happens at the last beat of a byte. In that same cycle the serializer sends the byte's final bit and the stream handshake must load the next byte. On the last byte, that cycle is also where the payload hands over to the CRC. The bench keeps `tx_valid_i` high throughout, so every byte boundary triggers a handshake in the very cycle of that final beat. It checks every captured beat against a stream it builds independently from the payload, and it counts the bytes taken. A second coincidence comes from toggling DAT1..DAT3 while the status and busy sequence runs on DAT0. The decoded code and the timing of the completion pulse are compared against the values the card model sent.

// File: rtl/sdb_pkg.sv
package sdb_pkg;
   localparam int unsigned LANES    = 4;
   localparam int unsigned CRC_W    = 16;
   localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;
   localparam int unsigned STAT_W   = 3;
   localparam logic [STAT_W-1:0] STAT_GOOD = 3'b010;

   typedef enum logic [2:0] {TX_IDLE, TX_FETCH, TX_START, TX_DATA, TX_CRC, TX_END} tx_state_e;
   typedef enum logic [2:0] {RX_IDLE, RX_HUNT, RX_DATA, RX_CRC, RX_TAIL} rx_state_e;
   typedef enum logic [2:0] {WS_IDLE, WS_START, WS_BITS, WS_STOP, WS_BUSY} ws_state_e;

   function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
      logic fb;
      fb = b ^ c[CRC_W-1];
      return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
   endfunction
endpackage

// File: rtl/sdb_crc16.sv
module sdb_crc16 import sdb_pkg::*; (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             en_i,
   input  logic             bit_i,
   output logic [CRC_W-1:0] crc_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)      crc_o <= '0;
      else if (clr_i)  crc_o <= '0;
      else if (en_i)   crc_o <= crc_step(crc_o, bit_i);
   end
endmodule

// File: rtl/sdb_tx.sv
module sdb_tx import sdb_pkg::*; #(
   parameter int unsigned BLK_BYTES = 512
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wide_i,
   input  logic             start_i,
   input  logic [7:0]       data_i,
   input  logic             valid_i,
   output logic             ready_o,
   output logic [LANES-1:0] dat_o,
   output logic [LANES-1:0] oe_o,
   output logic             end_o,
   output logic             busy_o
);
   localparam int unsigned LW = (BLK_BYTES > 1) ? $clog2(BLK_BYTES) : 1;
   localparam logic [LW-1:0] LAST_IDX = LW'(BLK_BYTES - 1);

   tx_state_e        st;
   logic [7:0]       sh;
   logic [2:0]       beat;
   logic [LW-1:0]    left;
   logic [3:0]       ccnt;
   logic             wide_q;
   logic [LANES-1:0] lane_bit;
   logic [LANES-1:0] lane_act;
   logic [CRC_W-1:0] crc_v [LANES];
   logic             need_byte, stall, advance, driving;
   logic [2:0]       reload;

   assign reload    = wide_q ? 3'd1 : 3'd7;
   assign need_byte = (st == TX_DATA) && (beat == 3'd0) && (left != '0);
   assign stall     = need_byte && !valid_i;
   assign advance   = (st == TX_DATA) && !stall;
   assign ready_o   = (st == TX_FETCH) || need_byte;
   assign driving   = (st == TX_START) || (st == TX_DATA) || (st == TX_CRC) || (st == TX_END);
   assign end_o     = (st == TX_END);
   assign busy_o    = (st != TX_IDLE);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_act[g] = wide_q || (g == 0);
      if (g == 0) begin : g_first
         assign lane_bit[g] = wide_q ? sh[4] : sh[7];
      end else begin : g_other
         assign lane_bit[g] = wide_q ? sh[4+g] : 1'b1;
      end
      sdb_crc16 u_crc (
         .clk   (clk),
         .rst_n (rst_n),
         .clr_i (st == TX_START),
         .en_i  (advance && lane_act[g]),
         .bit_i (lane_bit[g]),
         .crc_o (crc_v[g])
      );
      assign dat_o[g] = (st == TX_DATA)  ? lane_bit[g] :
                        (st == TX_CRC)   ? crc_v[g][ccnt] :
                        (st == TX_START) ? 1'b0 : 1'b1;
      assign oe_o[g]  = driving && lane_act[g];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= TX_IDLE;
         sh     <= '0;
         beat   <= '0;
         left   <= '0;
         ccnt   <= '0;
         wide_q <= 1'b0;
      end else begin
         unique case (st)
            TX_IDLE: if (start_i) begin
               wide_q <= wide_i;
               st     <= TX_FETCH;
            end
            TX_FETCH: if (valid_i) begin
               sh   <= data_i;
               left <= LAST_IDX;
               beat <= reload;
               st   <= TX_START;
            end
            TX_START: st <= TX_DATA;
            TX_DATA: if (advance) begin
               if (beat == 3'd0) begin
                  if (left == '0) begin
                     st   <= TX_CRC;
                     ccnt <= 4'd15;
                  end else begin
                     sh   <= data_i;
                     left <= left - 1'b1;
                     beat <= reload;
                  end
               end else begin
                  sh   <= wide_q ? {sh[3:0], 4'h0} : {sh[6:0], 1'b0};
                  beat <= beat - 1'b1;
               end
            end
            TX_CRC: begin
               if (ccnt == 4'd0) st <= TX_END;
               else              ccnt <= ccnt - 1'b1;
            end
            TX_END:  st <= TX_IDLE;
            default: st <= TX_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sdb_rx.sv
module sdb_rx import sdb_pkg::*; #(
   parameter int unsigned BLK_BYTES = 512
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wide_i,
   input  logic             start_i,
   input  logic [LANES-1:0] dat_i,
   output logic [7:0]       data_o,
   output logic             valid_o,
   output logic             done_o,
   output logic             err_o,
   output logic             busy_o
);
   localparam int unsigned LW = (BLK_BYTES > 1) ? $clog2(BLK_BYTES) : 1;
   localparam logic [LW-1:0] LAST_IDX = LW'(BLK_BYTES - 1);

   rx_state_e        st;
   logic [7:0]       sh, nxt_sh;
   logic [2:0]       beat;
   logic [LW-1:0]    left;
   logic [3:0]       ccnt;
   logic             wide_q;
   logic [LANES-1:0] lane_act;
   logic [LANES-1:0] lane_bad;
   logic [CRC_W-1:0] crc_v [LANES];
   logic             sampling;

   assign nxt_sh   = wide_q ? {sh[3:0], dat_i} : {sh[6:0], dat_i[0]};
   assign sampling = (st == RX_DATA) || (st == RX_CRC);
   assign busy_o   = (st != RX_IDLE);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_act[g] = wide_q || (g == 0);
      sdb_crc16 u_crc (
         .clk   (clk),
         .rst_n (rst_n),
         .clr_i (st == RX_HUNT),
         .en_i  (sampling && lane_act[g]),
         .bit_i (dat_i[g]),
         .crc_o (crc_v[g])
      );
      assign lane_bad[g] = lane_act[g] && ((crc_v[g] != '0) || !dat_i[g]);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= RX_IDLE;
         sh      <= '0;
         beat    <= '0;
         left    <= '0;
         ccnt    <= '0;
         wide_q  <= 1'b0;
         data_o  <= '0;
         valid_o <= 1'b0;
         done_o  <= 1'b0;
         err_o   <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         done_o  <= 1'b0;
         unique case (st)
            RX_IDLE: if (start_i) begin
               wide_q <= wide_i;
               st     <= RX_HUNT;
            end
            RX_HUNT: if (!dat_i[0]) begin
               beat <= wide_q ? 3'd1 : 3'd7;
               left <= LAST_IDX;
               st   <= RX_DATA;
            end
            RX_DATA: begin
               sh <= nxt_sh;
               if (beat == 3'd0) begin
                  data_o  <= nxt_sh;
                  valid_o <= 1'b1;
                  if (left == '0) begin
                     st   <= RX_CRC;
                     ccnt <= 4'd15;
                  end else begin
                     left <= left - 1'b1;
                     beat <= wide_q ? 3'd1 : 3'd7;
                  end
               end else begin
                  beat <= beat - 1'b1;
               end
            end
            RX_CRC: begin
               if (ccnt == 4'd0) st <= RX_TAIL;
               else              ccnt <= ccnt - 1'b1;
            end
            RX_TAIL: begin
               done_o <= 1'b1;
               err_o  <= |lane_bad;
               st     <= RX_IDLE;
            end
            default: st <= RX_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sdb_wr_status.sv
module sdb_wr_status import sdb_pkg::*; (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arm_i,
   input  logic              dat0_i,
   output logic              done_o,
   output logic [STAT_W-1:0] status_o,
   output logic              busy_o
);
   ws_state_e  st;
   logic [1:0] cnt;

   assign busy_o = (st != WS_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= WS_IDLE;
         cnt      <= '0;
         status_o <= '0;
         done_o   <= 1'b0;
      end else begin
         done_o <= 1'b0;
         unique case (st)
            WS_IDLE:  if (arm_i) st <= WS_START;
            WS_START: if (!dat0_i) begin
               cnt <= 2'(STAT_W - 1);
               st  <= WS_BITS;
            end
            WS_BITS: begin
               status_o <= {status_o[STAT_W-2:0], dat0_i};
               if (cnt == 2'd0) st <= WS_STOP;
               else             cnt <= cnt - 1'b1;
            end
            WS_STOP:  st <= WS_BUSY;
            WS_BUSY:  if (dat0_i) begin
               done_o <= 1'b1;
               st     <= WS_IDLE;
            end
            default:  st <= WS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sd_blk_dat_engine.sv
module sd_blk_dat_engine import sdb_pkg::*; #(
   parameter int unsigned BLK_BYTES = 512
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wide_i,
   input  logic        tx_start_i,
   input  logic [7:0]  tx_data_i,
   input  logic        tx_valid_i,
   output logic        tx_ready_o,
   input  logic        rx_start_i,
   output logic [7:0]  rx_data_o,
   output logic        rx_valid_o,
   output logic        rx_done_o,
   output logic        rx_err_o,
   output logic        wr_done_o,
   output logic [2:0]  wr_status_o,
   output logic        wr_ok_o,
   input  logic [3:0]  dat_i,
   output logic [3:0]  dat_o,
   output logic [3:0]  dat_oe_o,
   output logic        busy_o
);
   if (BLK_BYTES < 1 || BLK_BYTES > 65536) begin : g_bad_len
      $error("BLK_BYTES must lie in 1..65536");
   end
   if (LANES != 4 || STAT_W != 3) begin : g_bad_pkg
      $error("package widths do not match the port list");
   end

   logic tx_end, tx_busy, rx_busy, ws_busy;

   sdb_tx #(.BLK_BYTES(BLK_BYTES)) u_tx (
      .clk     (clk),
      .rst_n   (rst_n),
      .wide_i  (wide_i),
      .start_i (tx_start_i && !busy_o),
      .data_i  (tx_data_i),
      .valid_i (tx_valid_i),
      .ready_o (tx_ready_o),
      .dat_o   (dat_o),
      .oe_o    (dat_oe_o),
      .end_o   (tx_end),
      .busy_o  (tx_busy)
   );

   sdb_wr_status u_ws (
      .clk      (clk),
      .rst_n    (rst_n),
      .arm_i    (tx_end),
      .dat0_i   (dat_i[0]),
      .done_o   (wr_done_o),
      .status_o (wr_status_o),
      .busy_o   (ws_busy)
   );

   sdb_rx #(.BLK_BYTES(BLK_BYTES)) u_rx (
      .clk     (clk),
      .rst_n   (rst_n),
      .wide_i  (wide_i),
      .start_i (rx_start_i && !busy_o),
      .dat_i   (dat_i),
      .data_o  (rx_data_o),
      .valid_o (rx_valid_o),
      .done_o  (rx_done_o),
      .err_o   (rx_err_o),
      .busy_o  (rx_busy)
   );

   assign wr_ok_o = (wr_status_o == STAT_GOOD);
   assign busy_o  = tx_busy || rx_busy || ws_busy;
endmodule

// File: rtl/sdb_engine_chk.sv
module sdb_engine_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [3:0] dat_o,
   input logic [3:0] dat_oe_o,
   input logic [3:0] dat_i,
   input logic       tx_ready_o,
   input logic       rx_valid_o,
   input logic       rx_done_o,
   input logic       wr_done_o,
   input logic       busy_o
);
   assert_lane_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_oe_o == 4'h0) || (dat_oe_o == 4'h1) || (dat_oe_o == 4'hF));

   assert_start_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dat_oe_o[0]) |-> ((dat_o & dat_oe_o) == 4'h0));

   assert_end_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dat_oe_o[0]) |-> $past((dat_o & dat_oe_o) == dat_oe_o));

   assert_ready_in_xfer_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready_o |-> busy_o);

   assert_done_no_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done_o |-> !rx_valid_o);

   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done_o |=> !rx_done_o);

   assert_release_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_done_o |-> ($past(dat_i[0]) && $past(busy_o)));
endmodule

bind sd_blk_dat_engine sdb_engine_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .dat_o      (dat_o),
   .dat_oe_o   (dat_oe_o),
   .dat_i      (dat_i),
   .tx_ready_o (tx_ready_o),
   .rx_valid_o (rx_valid_o),
   .rx_done_o  (rx_done_o),
   .wr_done_o  (wr_done_o),
   .busy_o     (busy_o)
);

// File: tb/sd_blk_dat_engine_tb_top.sv
module sd_blk_dat_engine_tb_top;
   localparam int BLK = 512;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       wide_i, tx_start_i, tx_valid_i, tx_ready_o, rx_start_i;
   logic [7:0] tx_data_i, rx_data_o;
   logic       rx_valid_o, rx_done_o, rx_err_o, wr_done_o, wr_ok_o, busy_o;
   logic [2:0] wr_status_o;
   logic [3:0] dat_i, dat_o, dat_oe_o;

   int  n_tests = 0;
   int  n_fail  = 0;
   bit  finished = 1'b0;
   int  tx_idx = 0;
   logic [7:0] pay [BLK];
   logic [7:0] rx_q [$];
   logic [2:0] ws_q [$];

   always #10 clk = ~clk;

   sd_blk_dat_engine dut_i (
      .clk(clk), .rst_n(rst_n), .wide_i(wide_i),
      .tx_start_i(tx_start_i), .tx_data_i(tx_data_i), .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o),
      .rx_start_i(rx_start_i), .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o),
      .rx_done_o(rx_done_o), .rx_err_o(rx_err_o),
      .wr_done_o(wr_done_o), .wr_status_o(wr_status_o), .wr_ok_o(wr_ok_o),
      .dat_i(dat_i), .dat_o(dat_o), .dat_oe_o(dat_oe_o), .busy_o(busy_o)
   );

   always_comb tx_data_i = (tx_idx < BLK) ? pay[tx_idx] : 8'h00;
   always @(posedge clk) if (tx_ready_o && tx_valid_i) tx_idx <= tx_idx + 1;

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] crc_add(input logic [15:0] c, input logic b);
      logic [15:0] r;
      r = c << 1;
      if (b ^ c[15]) r = r ^ 16'h1021;
      return r;
   endfunction

   function automatic logic data_bit(input int lane, input int k, input bit wide);
      if (wide) return pay[k/2][((k % 2) == 0 ? 4 : 0) + lane];
      return pay[k/8][7 - (k % 8)];
   endfunction

   // expected level of an active lane in beat k of a framed block
   function automatic logic beat_bit(input int lane, input int k, input bit wide, input logic [15:0] c);
      int d;
      d = BLK * (wide ? 2 : 8);
      if (k == 0)       return 1'b0;
      if (k <= d)       return data_bit(lane, k - 1, wide);
      if (k <= d + 16)  return c[15 - (k - d - 1)];
      return 1'b1;
   endfunction

   task automatic fill(input int seed);
      for (int i = 0; i < BLK; i++) pay[i] = 8'((i * 37 + seed * 11) ^ (i >> 3));
   endtask

   task automatic lane_crcs(input bit wide, output logic [15:0] c0, output logic [15:0] c1,
                            output logic [15:0] c2, output logic [15:0] c3);
      logic [15:0] c [4];
      int d;
      d = BLK * (wide ? 2 : 8);
      for (int l = 0; l < 4; l++) begin
         c[l] = 16'h0;
         for (int k = 0; k < d; k++) c[l] = crc_add(c[l], data_bit(l, k, wide));
      end
      c0 = c[0]; c1 = c[1]; c2 = c[2]; c3 = c[3];
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      logic [7:0] eb;
      logic [2:0] es;
      if (rst_n) begin
         if (rx_valid_o) begin
            if (rx_q.size() == 0) check(1'b0, "R6", "byte with empty queue", rx_data_o, 0);
            else begin
               eb = rx_q.pop_front();
               check(rx_data_o == eb, "R6", "received byte", rx_data_o, eb);
            end
         end
         if (wr_done_o) begin
            if (ws_q.size() == 0) check(1'b0, "R9", "status with empty queue", wr_status_o, 0);
            else begin
               es = ws_q.pop_front();
               check(wr_status_o == es, "R9", "write status code", wr_status_o, es);
            end
         end
      end
   end

   task automatic run_tx(input bit wide, input logic [2:0] code, input bit noise, input int seed);
      logic [15:0] c [4];
      logic [3:0]  act;
      int d, k, bad_oe, bad_frame, bad_data, bad_crc;
      logic e;
      d = BLK * (wide ? 2 : 8);
      act = wide ? 4'hF : 4'h1;
      bad_oe = 0; bad_frame = 0; bad_data = 0; bad_crc = 0;
      fill(seed);
      lane_crcs(wide, c[0], c[1], c[2], c[3]);
      @(negedge clk);
      wide_i = wide; tx_idx = 0; tx_valid_i = 1'b0; tx_start_i = 1'b1;
      @(negedge clk);
      tx_start_i = 1'b0;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check(dat_oe_o == 4'h0 && tx_ready_o, "R5", "lanes idle while first byte missing", dat_oe_o, 0);
      end
      tx_valid_i = 1'b1;
      k = 0;
      while (dat_oe_o == 4'h0 && k < 10) begin @(negedge clk); k++; end
      k = 0;
      while (dat_oe_o != 4'h0 && k < d + 40) begin
         if (dat_oe_o != act) bad_oe++;
         for (int l = 0; l < 4; l++) if (act[l]) begin
            e = beat_bit(l, k, wide, c[l]);
            if (dat_o[l] != e) begin
               if (k == 0 || k > d + 16) bad_frame++;
               else if (k <= d)          bad_data++;
               else                      bad_crc++;
            end
         end
         k++;
         @(negedge clk);
      end
      tx_valid_i = 1'b0;
      check(k == d + 18, "R5", "driven beat count", k, d + 18);
      check(tx_idx == BLK, "R5", "bytes taken from stream", tx_idx, BLK);
      check(bad_oe == 0, "R1", "lane enable pattern errors", bad_oe, 0);
      check(bad_frame == 0, "R2", "start/end beat errors", bad_frame, 0);
      check(bad_data == 0, "R3", "payload beat errors", bad_data, 0);
      check(bad_crc == 0, "R4", "lane CRC beat errors", bad_crc, 0);
      // card reply on DAT0; other lanes optionally toggling
      ws_q.push_back(code);
      dat_i = 4'hF;
      @(negedge clk);
      for (int b = 0; b < 5; b++) begin
         dat_i[0] = (b == 0) ? 1'b0 : (b == 4) ? 1'b1 : code[3 - b];
         dat_i[3:1] = noise ? 3'(b * 5 + 2) : 3'b111;
         @(negedge clk);
      end
      for (int b = 0; b < 20; b++) begin
         dat_i[0] = 1'b0;
         dat_i[3:1] = noise ? 3'(b * 3) : 3'b111;
         @(negedge clk);
         check(!wr_done_o, "R10", "done while line held low", wr_done_o, 0);
      end
      dat_i = 4'hF;
      @(negedge clk);
      check(wr_done_o, "R10", "done one cycle after release", wr_done_o, 1);
      check(wr_ok_o == (code == 3'b010), "R9", "accept flag", wr_ok_o, (code == 3'b010));
      if (noise) check(wr_status_o == code, "R11", "status under DAT1-3 noise", wr_status_o, code);
      @(negedge clk);
   endtask

   // mode 0: clean, 1: flip one CRC beat on lane ln, 2: end beat 0 on lane ln
   task automatic run_rx(input bit wide, input int mode, input int ln, input int seed);
      logic [15:0] c [4];
      logic [3:0]  act, v;
      int d, tot;
      d = BLK * (wide ? 2 : 8);
      tot = d + 18;
      act = wide ? 4'hF : 4'h1;
      fill(seed);
      lane_crcs(wide, c[0], c[1], c[2], c[3]);
      for (int i = 0; i < BLK; i++) rx_q.push_back(pay[i]);
      @(negedge clk);
      wide_i = wide; rx_start_i = 1'b1; dat_i = 4'hF;
      @(negedge clk);
      rx_start_i = 1'b0;
      repeat (2) @(negedge clk);
      for (int k = 0; k < tot; k++) begin
         v = wide ? 4'hF : {3'(k * 7), 1'b1};
         for (int l = 0; l < 4; l++) if (act[l]) begin
            v[l] = beat_bit(l, k, wide, c[l]);
            if (mode == 1 && l == ln && k == d + 6) v[l] = ~v[l];
            if (mode == 2 && l == ln && k == tot - 1) v[l] = 1'b0;
         end
         dat_i = v;
         @(negedge clk);
      end
      dat_i = 4'hF;
      check(rx_done_o, "R7", "block end strobe", rx_done_o, 1);
      if (mode == 2) check(rx_err_o, "R8", "bad end beat flagged", rx_err_o, 1);
      else           check(rx_err_o == (mode == 1), "R7", "lane CRC verdict", rx_err_o, (mode == 1));
      check(rx_q.size() == 0, "R6", "bytes left undelivered", rx_q.size(), 0);
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; dat_i = 4'hF; wide_i = 1'b0;
      tx_start_i = 1'b0; tx_valid_i = 1'b0; rx_start_i = 1'b0;
      repeat (3) @(negedge clk);
      check(dat_oe_o == 4'h0, "R12", "reset lane enables", dat_oe_o, 0);
      check(!tx_ready_o && !busy_o, "R12", "reset ready/busy", {tx_ready_o, busy_o}, 0);
      check(!rx_valid_o && !rx_done_o && !wr_done_o, "R12", "reset strobes",
            {rx_valid_o, rx_done_o, wr_done_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      run_tx(1'b0, 3'b010, 1'b0, 1);
      run_tx(1'b1, 3'b101, 1'b1, 2);
      run_tx(1'b1, 3'b010, 1'b1, 3);
      run_rx(1'b1, 0, 0, 4);
      run_rx(1'b0, 0, 0, 5);
      run_rx(1'b1, 1, 2, 6);
      run_rx(1'b0, 1, 0, 7);
      run_rx(1'b0, 2, 0, 8);
      run_rx(1'b1, 2, 3, 9);
      check(ws_q.size() == 0, "R9", "status items left", ws_q.size(), 0);
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule